// File: doc/BRIEF.md
# Cartridge Real-Time Clock with Snapshot Latch

This block keeps wall-clock time for a banked cartridge: seconds, minutes, hours and a 9-bit day count. A battery keeps it running. A CPU reaches it over a byte-wide bus with a 16-bit address. Four address regions are decoded from the top three address bits. An access-enable region opens or closes the clock. A select region picks which clock register appears in a data window. A latch region freezes the live counters into a shadow copy. The data window reads the shadow copy and writes the live counters.

Time advances on pulses of `osc_tick`. Each group of `SUBTICKS` pulses makes one second. The default of 1 treats every pulse as a whole second. A halt bit stops timekeeping. A sticky carry flag records that the day count overflowed. Both live in the upper day register, together with bit 8 of the day count.

The snapshot is taken by a two-state sequencer. In `LATCH_IDLE`, a latch write of 0x00 moves it to `LATCH_ARMED`. In `LATCH_ARMED`, a write of 0x01 copies the live counters into the shadow and returns to `LATCH_IDLE`. Another write of 0x00 keeps it in `LATCH_ARMED`. Any other value returns it to `LATCH_IDLE` without a copy.

Top module: `cart_rtc`

## Requirements
- R1: A synchronous active-high `rst` clears all live counters, the shadow copy, the halt and carry flags, the select value and the sequencer state (`LATCH_IDLE`), and closes access. After reset, enabling access, latching and reading any clock register returns 0x00.
- R2: A write to addresses 0x0000–0x1FFF with data 0x0A opens access, and a write there of any other value (0x00 included) closes it. While access is closed, the data window 0xA000–0xBFFF reads 0xFF and writes to it have no effect. Reads of any address outside the data window return 0xFF.
- R3: After each `SUBTICKS` counted pulses of `osc_tick`, time advances by one second. Seconds and minutes run 0–59 and wrap to 0, each wrap incrementing the next field. Hours run 0–23, and their wrap increments the day count.
- R4: The day count is 9 bits wide. Select 0x0B reads bits 7:0. Select 0x0C reads bit 8 in data bit 0. An advance from day 511 gives day 0 and sets the carry flag, data bit 7 of select 0x0C. The flag stays set through further counting until software writes 0 to it.
- R5: Data bit 6 of select 0x0C is the halt control. While it is 1, neither the counters nor the sub-second prescaler change on `osc_tick`.
- R6: A write to 0x4000–0x5FFF stores the select value. The values 0x08 seconds, 0x09 minutes, 0x0A hours, 0x0B day low and 0x0C day high/control map a clock register into the data window. Any other select value makes the window read 0xFF and ignore writes.
- R7: Window reads always return the shadow copy. The shadow changes only when a latch write (0x6000–0x7FFF) of 0x01 directly follows a latch write of 0x00. Any other sequence of latch writes leaves it unchanged.
- R8: A window write updates the live counter directly, keeping 6 bits for seconds and minutes, 5 bits for hours and 8 bits for day low. A write to seconds also clears the sub-second prescaler. An `osc_tick` in the same cycle as any window write to a clock register is dropped.
- R9: Bits 5:1 of select 0x0C always read 0. The data written to those bits is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | Timebase pulse, `SUBTICKS` pulses per second |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |

## Verification
Every read goes through the shadow copy. A wrong live counter, prescaler phase or carry flag is therefore invisible at `bus_rdata` until the next latch sequence. After that sequence it shows in the very next read, in the cycle after the firing write. A wrong enable or select register shows at once as a wrong 0xFF or non-0xFF read in the window. A sequencer that latches on the wrong sequence shows as a shadow that changes when it should hold. A per-cycle behavioural model compares every read, and latches at chosen moments expose the live state.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int RGN_W  = 3;

    localparam logic [RGN_W-1:0] RGN_ENABLE = 3'b000;
    localparam logic [RGN_W-1:0] RGN_SELECT = 3'b010;
    localparam logic [RGN_W-1:0] RGN_LATCH  = 3'b011;
    localparam logic [RGN_W-1:0] RGN_WINDOW = 3'b101;

    localparam logic [DATA_W-1:0] KEY_OPEN   = 8'h0A;
    localparam logic [DATA_W-1:0] LATCH_ARM  = 8'h00;
    localparam logic [DATA_W-1:0] LATCH_FIRE = 8'h01;
    localparam logic [DATA_W-1:0] BUS_IDLE   = 8'hFF;

    localparam logic [DATA_W-1:0] SEL_SEC = 8'h08;
    localparam logic [DATA_W-1:0] SEL_MIN = 8'h09;
    localparam logic [DATA_W-1:0] SEL_HR  = 8'h0A;
    localparam logic [DATA_W-1:0] SEL_DLO = 8'h0B;
    localparam logic [DATA_W-1:0] SEL_DHI = 8'h0C;

    localparam int SEC_W = 6;
    localparam int MIN_W = 6;
    localparam int HR_W  = 5;
    localparam int DAY_W = 9;

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [MIN_W-1:0] min;
        logic [HR_W-1:0]  hr;
        logic [DAY_W-1:0] day;
        logic             halt;
        logic             carry;
    } rtc_time_t;

    typedef enum logic [2:0] {
        REG_SEC,
        REG_MIN,
        REG_HR,
        REG_DLO,
        REG_DHI,
        REG_NONE
    } reg_idx_t;

    typedef enum logic {
        LATCH_IDLE,
        LATCH_ARMED
    } latch_state_t;

endpackage

// File: rtl/rtc_counters.sv
module rtc_counters
    import rtc_pkg::*;
#(
    parameter int SUBTICKS = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              osc_tick,
    input  logic              rtc_wr,
    input  reg_idx_t          rtc_idx,
    input  logic [DATA_W-1:0] wdata,
    output rtc_time_t         live
);

    localparam int PRE_W = (SUBTICKS > 1) ? $clog2(SUBTICKS) : 1;

    logic tick_ok;
    logic sec_pulse;
    logic sec_wrap, min_wrap, hr_wrap, day_wrap;

    assign tick_ok  = osc_tick && !live.halt && !rtc_wr;
    assign sec_wrap = (live.sec == SEC_W'(59));
    assign min_wrap = (live.min == MIN_W'(59));
    assign hr_wrap  = (live.hr  == HR_W'(23));
    assign day_wrap = (live.day == {DAY_W{1'b1}});

    generate
        if (SUBTICKS > 1) begin : g_prescale
            localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(SUBTICKS - 1);
            logic [PRE_W-1:0] pre_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    pre_q <= '0;
                end else if (rtc_wr && rtc_idx == REG_SEC) begin
                    pre_q <= '0;
                end else if (tick_ok) begin
                    pre_q <= (pre_q == PRE_LAST) ? '0 : pre_q + PRE_W'(1);
                end
            end
            assign sec_pulse = tick_ok && (pre_q == PRE_LAST);
        end else begin : g_direct
            assign sec_pulse = tick_ok;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            live <= '0;
        end else if (rtc_wr) begin
            unique case (rtc_idx)
                REG_SEC: live.sec <= wdata[SEC_W-1:0];
                REG_MIN: live.min <= wdata[MIN_W-1:0];
                REG_HR:  live.hr  <= wdata[HR_W-1:0];
                REG_DLO: live.day[7:0] <= wdata;
                REG_DHI: begin
                    live.day[8] <= wdata[0];
                    live.halt   <= wdata[6];
                    live.carry  <= wdata[7];
                end
                default: ;
            endcase
        end else if (sec_pulse) begin
            if (!sec_wrap) begin
                live.sec <= live.sec + SEC_W'(1);
            end else begin
                live.sec <= '0;
                if (!min_wrap) begin
                    live.min <= live.min + MIN_W'(1);
                end else begin
                    live.min <= '0;
                    if (!hr_wrap) begin
                        live.hr <= live.hr + HR_W'(1);
                    end else begin
                        live.hr  <= '0;
                        live.day <= live.day + DAY_W'(1);
                        if (day_wrap) live.carry <= 1'b1;
                    end
                end
            end
        end
    end

    // R3: the seconds field wraps from 59 to 0
    a_r3_sec_wrap: assert property (@(posedge clk) disable iff (rst)
        sec_pulse && live.sec == SEC_W'(59) |=> live.sec == '0);

    // R4: carry only clears through a write of the control register
    a_r4_carry_sticky: assert property (@(posedge clk) disable iff (rst)
        live.carry && !(rtc_wr && rtc_idx == REG_DHI) |=> live.carry);

    // R5: a halted clock does not move without a write
    a_r5_halt_freeze: assert property (@(posedge clk) disable iff (rst)
        live.halt && !rtc_wr |=> $stable(live));

    // R8: a minutes write lands in the live counter
    a_r8_write_wins: assert property (@(posedge clk) disable iff (rst)
        rtc_wr && rtc_idx == REG_MIN |=> live.min == $past(wdata[MIN_W-1:0]));

endmodule

// File: rtl/rtc_latch_fsm.sv
module rtc_latch_fsm
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              latch_wr,
    input  logic [DATA_W-1:0] wdata,
    input  rtc_time_t         live,
    output rtc_time_t         shadow
);

    latch_state_t state_q, state_d;
    logic         fire;

    always_ff @(posedge clk) begin
        if (rst) state_q <= LATCH_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        fire    = 1'b0;
        if (latch_wr) begin
            unique case (state_q)
                LATCH_IDLE: begin
                    if (wdata == LATCH_ARM) state_d = LATCH_ARMED;
                end
                LATCH_ARMED: begin
                    if (wdata == LATCH_FIRE) begin
                        fire    = 1'b1;
                        state_d = LATCH_IDLE;
                    end else if (wdata != LATCH_ARM) begin
                        state_d = LATCH_IDLE;
                    end
                end
                default: state_d = LATCH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)       shadow <= '0;
        else if (fire) shadow <= live;
    end

    // R7: a firing write copies the counters of that cycle
    a_r7_latch_copy: assert property (@(posedge clk) disable iff (rst)
        fire |=> shadow == $past(live));

    // R7: without a firing write the shadow holds
    a_r7_shadow_hold: assert property (@(posedge clk) disable iff (rst)
        !fire |=> $stable(shadow));

endmodule

// File: rtl/rtc_regif.sv
module rtc_regif
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  rtc_time_t         shadow,
    output logic              rtc_wr,
    output reg_idx_t          rtc_idx,
    output logic              latch_wr,
    output logic [DATA_W-1:0] bus_rdata
);

    logic [RGN_W-1:0]  rgn;
    logic              in_window;
    logic              open_q;
    logic [DATA_W-1:0] sel_q;
    logic [ADDR_W-RGN_W-1:0] unused_addr;

    assign rgn         = bus_addr[ADDR_W-1:ADDR_W-RGN_W];
    assign unused_addr = bus_addr[ADDR_W-RGN_W-1:0];
    assign in_window   = (rgn == RGN_WINDOW);
    assign latch_wr    = bus_we && (rgn == RGN_LATCH);

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            sel_q  <= '0;
        end else if (bus_we) begin
            if (rgn == RGN_ENABLE) open_q <= (bus_wdata == KEY_OPEN);
            if (rgn == RGN_SELECT) sel_q  <= bus_wdata;
        end
    end

    always_comb begin
        unique case (sel_q)
            SEL_SEC: rtc_idx = REG_SEC;
            SEL_MIN: rtc_idx = REG_MIN;
            SEL_HR:  rtc_idx = REG_HR;
            SEL_DLO: rtc_idx = REG_DLO;
            SEL_DHI: rtc_idx = REG_DHI;
            default: rtc_idx = REG_NONE;
        endcase
    end

    assign rtc_wr = bus_we && in_window && open_q && (rtc_idx != REG_NONE);

    always_comb begin
        bus_rdata = BUS_IDLE;
        if (in_window && open_q) begin
            unique case (rtc_idx)
                REG_SEC: bus_rdata = DATA_W'(shadow.sec);
                REG_MIN: bus_rdata = DATA_W'(shadow.min);
                REG_HR:  bus_rdata = DATA_W'(shadow.hr);
                REG_DLO: bus_rdata = shadow.day[7:0];
                REG_DHI: bus_rdata = {shadow.carry, shadow.halt, 5'b0, shadow.day[8]};
                default: bus_rdata = BUS_IDLE;
            endcase
        end
    end

    // R2: a closed clock presents idle data in the window
    a_r2_closed_idle: assert property (@(posedge clk) disable iff (rst)
        !open_q && in_window |-> bus_rdata == BUS_IDLE);

    // R6: a select value outside the clock set presents idle data
    a_r6_unmapped_idle: assert property (@(posedge clk) disable iff (rst)
        in_window && (sel_q < SEL_SEC || sel_q > SEL_DHI) |-> bus_rdata == BUS_IDLE);

    // R9: the unused control bits read as zero
    a_r9_dhi_zero: assert property (@(posedge clk) disable iff (rst)
        in_window && open_q && sel_q == SEL_DHI |-> bus_rdata[5:1] == 5'b0);

endmodule

// File: rtl/cart_rtc.sv
module cart_rtc
    import rtc_pkg::*;
#(
    parameter int SUBTICKS = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              osc_tick,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata
);

    rtc_time_t live, shadow;
    logic      rtc_wr, latch_wr;
    reg_idx_t  rtc_idx;

    rtc_regif u_regif (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .shadow    (shadow),
        .rtc_wr    (rtc_wr),
        .rtc_idx   (rtc_idx),
        .latch_wr  (latch_wr),
        .bus_rdata (bus_rdata)
    );

    rtc_counters #(.SUBTICKS(SUBTICKS)) u_counters (
        .clk      (clk),
        .rst      (rst),
        .osc_tick (osc_tick),
        .rtc_wr   (rtc_wr),
        .rtc_idx  (rtc_idx),
        .wdata    (bus_wdata),
        .live     (live)
    );

    rtc_latch_fsm u_latch (
        .clk      (clk),
        .rst      (rst),
        .latch_wr (latch_wr),
        .wdata    (bus_wdata),
        .live     (live),
        .shadow   (shadow)
    );

endmodule

// File: tb/cart_rtc_tb.sv
`timescale 1ns/1ps
module cart_rtc_tb;

    localparam int SUB = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        osc_tick = 1'b0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_addr = 16'h0100;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;

    int n_run = 0;
    int n_fail = 0;

    int m_sec, m_min, m_hr, m_day, m_halt, m_carry, m_pre, m_en, m_sel, m_armed;
    int s_sec, s_min, s_hr, s_day, s_halt, s_carry;
    bit m_rw;

    cart_rtc #(.SUBTICKS(SUB)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .osc_tick  (osc_tick),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata)
    );

    always #2 clk = ~clk;

    function automatic int m_read(input logic [15:0] a);
        if (a[15:13] != 3'b101 || m_en == 0) return 255;
        case (m_sel)
            8:  return s_sec;
            9:  return s_min;
            10: return s_hr;
            11: return s_day % 256;
            12: return s_carry * 128 + s_halt * 64 + s_day / 256;
            default: return 255;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_sec = 0; m_min = 0; m_hr = 0; m_day = 0; m_halt = 0; m_carry = 0;
            m_pre = 0; m_en = 0; m_sel = 0; m_armed = 0;
            s_sec = 0; s_min = 0; s_hr = 0; s_day = 0; s_halt = 0; s_carry = 0;
        end else begin
            m_rw = bus_we && bus_addr[15:13] == 3'b101 && m_en != 0 && m_sel >= 8 && m_sel <= 12;
            if (bus_we && bus_addr[15:13] == 3'b011) begin
                if (m_armed != 0 && bus_wdata == 8'h01) begin
                    s_sec = m_sec; s_min = m_min; s_hr = m_hr; s_day = m_day;
                    s_halt = m_halt; s_carry = m_carry;
                end
                m_armed = (bus_wdata == 8'h00) ? 1 : 0;
            end
            if (bus_we && bus_addr[15:13] == 3'b000) m_en = (bus_wdata == 8'h0A) ? 1 : 0;
            if (bus_we && bus_addr[15:13] == 3'b010) m_sel = bus_wdata;
            if (m_rw) begin
                case (m_sel)
                    8:  begin m_sec = bus_wdata % 64; m_pre = 0; end
                    9:  m_min = bus_wdata % 64;
                    10: m_hr = bus_wdata % 32;
                    11: m_day = (m_day / 256) * 256 + bus_wdata;
                    default: begin
                        m_day = (m_day % 256) + 256 * bus_wdata[0];
                        m_halt = bus_wdata[6];
                        m_carry = bus_wdata[7];
                    end
                endcase
            end else if (osc_tick && m_halt == 0) begin
                if (m_pre == SUB - 1) begin
                    m_pre = 0;
                    m_sec++;
                    if (m_sec == 60) begin
                        m_sec = 0; m_min++;
                        if (m_min == 60) begin
                            m_min = 0; m_hr++;
                            if (m_hr == 24) begin
                                m_hr = 0; m_day++;
                                if (m_day == 512) begin m_day = 0; m_carry = 1; end
                            end
                        end
                    end
                end else begin
                    m_pre++;
                end
            end
        end
    end

    task automatic check(input logic [7:0] act, input int exp, input string tag);
        n_run++;
        if (act !== exp[7:0]) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp[7:0]);
        end
    endtask

    task automatic step(input bit we, input logic [15:0] a, input logic [7:0] d, input bit t);
        @(negedge clk);
        check(bus_rdata, m_read(bus_addr), "R7 model read");
        bus_we = we; bus_addr = a; bus_wdata = d; osc_tick = t;
    endtask

    task automatic wreg(input logic [7:0] sel, input logic [7:0] val);
        step(1'b1, 16'h4000, sel, 1'b0);
        step(1'b1, 16'hA000, val, 1'b0);
    endtask

    task automatic latch();
        step(1'b1, 16'h6000, 8'h00, 1'b0);
        step(1'b1, 16'h6000, 8'h01, 1'b0);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 16'h0100, 8'h00, 1'b1);
    endtask

    task automatic look(input logic [7:0] sel, input int exp, input string tag);
        step(1'b1, 16'h4000, sel, 1'b0);
        step(1'b0, 16'hA000, 8'h00, 1'b0);
        #1;
        check(bus_rdata, exp, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1 / R2: closed after reset
        step(1'b0, 16'hA000, 8'h00, 1'b0);
        #1 check(bus_rdata, 255, "R2 closed after reset");
        step(1'b1, 16'h0000, 8'h0A, 1'b0);
        latch();
        look(8'h08, 0, "R1 seconds after reset");
        look(8'h0C, 0, "R1 control after reset");

        // R3 / R4: full rollover from day 511 23:59:57
        wreg(8'h08, 8'h39);
        wreg(8'h09, 8'h3B);
        wreg(8'h0A, 8'h17);
        wreg(8'h0B, 8'hFF);
        wreg(8'h0C, 8'h01);
        ticks(3 * SUB);
        latch();
        look(8'h08, 0, "R3 seconds wrap");
        look(8'h09, 0, "R3 minutes wrap");
        look(8'h0A, 0, "R3 hours wrap");
        look(8'h0B, 0, "R4 day low wrap");
        look(8'h0C, 8'h80, "R4 carry set, day bit 8 clear");

        // R4: carry stays set
        ticks(4 * SUB);
        latch();
        look(8'h08, 4, "R3 seconds count");
        look(8'h0C, 8'h80, "R4 carry sticky");

        // R7: shadow holds without a proper sequence
        ticks(2 * SUB);
        look(8'h08, 4, "R7 reads shadow not live");
        step(1'b1, 16'h6000, 8'h01, 1'b0);
        look(8'h08, 4, "R7 lone fire ignored");
        step(1'b1, 16'h6000, 8'h00, 1'b0);
        step(1'b1, 16'h6000, 8'h05, 1'b0);
        step(1'b1, 16'h6000, 8'h01, 1'b0);
        look(8'h08, 4, "R7 broken sequence ignored");
        latch();
        look(8'h08, 6, "R7 proper sequence copies");

        // R5 / R9: halt, carry clear, unused bits
        wreg(8'h0C, 8'h40);
        ticks(5 * SUB);
        latch();
        look(8'h08, 6, "R5 halted seconds frozen");
        look(8'h0C, 8'h40, "R4 carry cleared by write");
        wreg(8'h0C, 8'h7E);
        latch();
        look(8'h0C, 8'h40, "R9 unused bits read zero");
        wreg(8'h0C, 8'h00);

        // R8: seconds write clears prescaler, tick during write dropped
        wreg(8'h08, 8'h0A);
        ticks(2);
        wreg(8'h08, 8'h0A);
        ticks(SUB - 1);
        latch();
        look(8'h08, 10, "R8 prescaler cleared by seconds write");
        ticks(1);
        latch();
        look(8'h08, 11, "R8 second after full prescale");
        step(1'b1, 16'h4000, 8'h08, 1'b0);
        step(1'b1, 16'hA000, 8'h14, 1'b1);
        ticks(SUB - 1);
        latch();
        look(8'h08, 20, "R8 tick in write cycle dropped");

        // R3: minute carry from seconds
        wreg(8'h08, 8'h32);
        wreg(8'h09, 8'h07);
        ticks(40 * SUB);
        latch();
        look(8'h08, 30, "R3 seconds after 40 s");
        look(8'h09, 8, "R3 minute incremented");

        // R6: unmapped select values
        look(8'h03, 255, "R6 select 0x03 idle");
        step(1'b1, 16'hA000, 8'h00, 1'b0);
        look(8'h0D, 255, "R6 select 0x0D idle");
        latch();
        look(8'h08, 30, "R6 write with unmapped select ignored");

        // R2: closing, writes ignored, other key values
        step(1'b1, 16'h0000, 8'h00, 1'b0);
        step(1'b0, 16'hA000, 8'h00, 1'b0);
        #1 check(bus_rdata, 255, "R2 closed by 0x00");
        step(1'b1, 16'hA000, 8'h22, 1'b0);
        step(1'b1, 16'h0000, 8'h0A, 1'b0);
        latch();
        look(8'h08, 30, "R2 write while closed ignored");
        step(1'b1, 16'h1FFF, 8'h05, 1'b0);
        step(1'b0, 16'hBFFF, 8'h00, 1'b0);
        #1 check(bus_rdata, 255, "R2 closed by other value");
        step(1'b1, 16'h0000, 8'h0A, 1'b0);
        step(1'b0, 16'h1234, 8'h00, 1'b0);
        #1 check(bus_rdata, 255, "R2 outside window idle");

        // long run, model compared each cycle
        for (int i = 0; i < 600; i++) begin
            step(1'b0, 16'hA000, 8'h00, 1'b1);
            if (i % 50 == 0) latch();
        end
        step(1'b0, 16'h0100, 8'h00, 1'b0);
        step(1'b0, 16'h0100, 8'h00, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule